// File: doc/BRIEF.md
# E1 Frame Alignment Synchronizer

This block recovers the 256-bit frame boundary of a serial E1 stream. One line bit arrives per clock on `bitIn`. The block hunts for the 7-bit frame alignment word that occupies bits 2 to 8 of timeslot 0 in alternate frames. It confirms a candidate over the two frames that follow, and then drives a free-running bit and timeslot position, a flag for the frame that carries the alignment word, and a strobe on the first bit of every frame.

When the block is aligned, it watches the alignment word in every alignment frame. Optionally it also watches bit 2 of timeslot 0 in the frames between them. It drops back into the hunt when errors persist. A new hunt can also be started from outside: by a rising edge on a manual request, or by a restart pulse from the downstream multiframe aligners. The loss-of-sync output covers the whole hunt. It also stays high until those aligners report that they are ready.

Top module: `e1_frame_sync`

## Requirements
- R1: While reset is active, `losOut` is 1, `bitCnt` and `tsCnt` are 0, `frameStrobe` is 1 and `fasFrame` is 0.
- R2: The position advances by one bit per clock. `bitCnt` counts 0..7 (0 = bit 1, first on the line) and `tsCnt` steps when `bitCnt` wraps. `frameStrobe` is 1 exactly when both are 0. `fasFrame` inverts at every wrap from timeslot 31 bit 7 to 0/0.
- R3: While hunting, when the seven most recent bits (the current one included, oldest first) equal 0011011, the position is reloaded so that the next bit reads timeslot 1, bit 0, and `fasFrame` becomes 1.
- R4: A candidate is accepted only if bit 2 of timeslot 0 (`bitCnt` 1) in the following frame is 1 and the full 0011011 word is present again two frames after the candidate. Acceptance happens at bit 8 of that second word. `losOut` then falls in the next cycle, provided `mfReady` is 1.
- R5: A candidate that fails either confirmation returns the block to the hunt. The hunt continues with the bit after the failed check, so a spurious word in the payload does not produce a lock.
- R6: When aligned with `autoEn`=1, three errored alignment words in a row start a new hunt. A correct word clears the error run.
- R7: When aligned with `autoEn`=1 and `nfasChkEn`=1, bit 2 received as 0 in three non-alignment frames in a row starts a new hunt. With `nfasChkEn`=0 these errors never do.
- R8: With `autoEn`=0, errors of either kind never start a hunt.
- R9: A 0-to-1 change on `resyncIn` starts a hunt, with `losOut` high in the next cycle. Holding the input high or returning it to 0 has no further effect.
- R10: A cycle with `mfRestart`=1 starts a hunt, with `losOut` high in the next cycle.
- R11: `losOut` is 1 whenever the block is not aligned or `mfReady` is 0.
- R12: Error runs are not counted outside the aligned state. Errors seen before a hunt do not add to errors seen after the next lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| bitIn | input | 1 | Serial line data |
| resyncIn | input | 1 | Manual hunt request, acts on its rising edge |
| autoEn | input | 1 | 1 = error runs may start a hunt |
| nfasChkEn | input | 1 | 1 = bit-2 errors in non-alignment frames also count |
| mfRestart | input | 1 | Restart pulse from the multiframe aligners |
| mfReady | input | 1 | Multiframe aligners done (or unused) |
| bitCnt | output | 3 | Bit position of the current bit within its timeslot |
| tsCnt | output | 5 | Timeslot of the current bit |
| fasFrame | output | 1 | Current frame carries the alignment word |
| frameStrobe | output | 1 | Current bit is bit 0 of timeslot 0 |
| losOut | output | 1 | Loss of frame sync |

## Verification
A wrong position register shows up at once on `bitCnt`, `tsCnt` and `frameStrobe`, on the first bit after a realignment. A wrong alignment-frame phase shows up on `fasFrame` within one frame. Faults in the hunt or the confirmation steps show up as `losOut` falling too early or too late. This becomes visible within two or three frames of a planted spurious word or a cleared bit 2. Error-run faults show up only at the third errored frame, or at the first errored frame after a relock. They are visible within one cycle of that check point.

// File: rtl/e1fa_pkg.sv
package e1fa_pkg;

  typedef enum logic [1:0] {
    ST_HUNT     = 2'd0,
    ST_CHK_NFAS = 2'd1,
    ST_CHK_FAS  = 2'd2,
    ST_SYNC     = 2'd3
  } syncState_t;

  // control -> datapath
  typedef struct packed {
    logic realign;
  } ctlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic patHit;
    logic bit2One;
    logic checkPoint;
    logic fasPhase;
    logic resyncEdge;
  } dpFlags_t;

endpackage

// File: rtl/e1fa_datapath.sv
module e1fa_datapath
  import e1fa_pkg::*;
#(
  parameter int TS_BITS  = 8,
  parameter int FRAME_TS = 32,
  parameter logic [TS_BITS-2:0] FAS_WORD = 7'b0011011
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitIn,
  input  logic resyncIn,
  input  ctlStrobe_t strobe,
  output dpFlags_t flags,
  output logic [$clog2(TS_BITS*FRAME_TS)-1:0] pos
);
  localparam int FRAME_BITS = TS_BITS * FRAME_TS;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int WIN_W      = TS_BITS - 1;
  localparam logic [POS_W-1:0] CHK_POS     = POS_W'(TS_BITS - 1);
  localparam logic [POS_W-1:0] REALIGN_POS = POS_W'(TS_BITS);
  localparam logic [POS_W-1:0] LAST_POS    = POS_W'(FRAME_BITS - 1);

  logic [WIN_W-2:0] histQ;
  logic [WIN_W-1:0] nextWin;
  logic             fasPhQ;
  logic             resyncQ;

  assign nextWin = {histQ, bitIn};

  always_comb begin
    flags.patHit     = (nextWin == FAS_WORD);
    flags.bit2One    = nextWin[WIN_W-1];
    flags.checkPoint = (pos == CHK_POS);
    flags.fasPhase   = fasPhQ;
    flags.resyncEdge = resyncIn & ~resyncQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      histQ   <= '0;
      resyncQ <= 1'b0;
    end else begin
      histQ   <= nextWin[WIN_W-2:0];
      resyncQ <= resyncIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos    <= '0;
      fasPhQ <= 1'b0;
    end else if (strobe.realign) begin
      pos    <= REALIGN_POS;
      fasPhQ <= 1'b1;
    end else if (pos == LAST_POS) begin
      pos    <= '0;
      fasPhQ <= ~fasPhQ;
    end else begin
      pos    <= pos + 1'b1;
    end
  end

endmodule

// File: rtl/e1fa_control.sv
module e1fa_control
  import e1fa_pkg::*;
#(
  parameter int ERR_LIMIT = 3,
  parameter int ERR_W     = $clog2(ERR_LIMIT + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpFlags_t   flags,
  input  logic       autoEn,
  input  logic       nfasChkEn,
  input  logic       mfRestart,
  output ctlStrobe_t strobe,
  output syncState_t stateQ,
  output logic [ERR_W-1:0] fasErrCnt,
  output logic [ERR_W-1:0] nfasErrCnt
);
  localparam logic [ERR_W-1:0] LIMIT = ERR_W'(ERR_LIMIT);

  syncState_t       stateNext;
  logic [ERR_W-1:0] fasErrNext, nfasErrNext;
  logic             inSync, errRestart, forceHunt;

  assign inSync = (stateQ == ST_SYNC);

  // error runs, evaluated only at the check point of an aligned frame
  always_comb begin
    fasErrNext  = fasErrCnt;
    nfasErrNext = nfasErrCnt;
    if (inSync && flags.checkPoint) begin
      if (flags.fasPhase) begin
        if (flags.patHit)           fasErrNext = '0;
        else if (fasErrCnt != LIMIT) fasErrNext = fasErrCnt + 1'b1;
      end else begin
        if (flags.bit2One)           nfasErrNext = '0;
        else if (nfasErrCnt != LIMIT) nfasErrNext = nfasErrCnt + 1'b1;
      end
    end
  end

  always_comb begin
    errRestart = 1'b0;
    if (autoEn && inSync && flags.checkPoint) begin
      if (flags.fasPhase)
        errRestart = !flags.patHit && (fasErrNext == LIMIT);
      else
        errRestart = nfasChkEn && !flags.bit2One && (nfasErrNext == LIMIT);
    end
  end

  assign forceHunt = flags.resyncEdge | mfRestart | errRestart;

  always_comb begin
    stateNext      = stateQ;
    strobe.realign = 1'b0;
    if (forceHunt) begin
      stateNext = ST_HUNT;
    end else begin
      unique case (stateQ)
        ST_HUNT: begin
          if (flags.patHit) begin
            stateNext      = ST_CHK_NFAS;
            strobe.realign = 1'b1;
          end
        end
        ST_CHK_NFAS: begin
          if (flags.checkPoint)
            stateNext = flags.bit2One ? ST_CHK_FAS : ST_HUNT;
        end
        ST_CHK_FAS: begin
          if (flags.checkPoint)
            stateNext = flags.patHit ? ST_SYNC : ST_HUNT;
        end
        ST_SYNC: stateNext = ST_SYNC;
        default: stateNext = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ     <= ST_HUNT;
      fasErrCnt  <= '0;
      nfasErrCnt <= '0;
    end else begin
      stateQ <= stateNext;
      if (stateNext != ST_SYNC) begin
        fasErrCnt  <= '0;
        nfasErrCnt <= '0;
      end else begin
        fasErrCnt  <= fasErrNext;
        nfasErrCnt <= nfasErrNext;
      end
    end
  end

endmodule

// File: rtl/e1_frame_sync.sv
module e1_frame_sync
  import e1fa_pkg::*;
#(
  parameter int TS_BITS   = 8,
  parameter int FRAME_TS  = 32,
  parameter logic [TS_BITS-2:0] FAS_WORD = 7'b0011011,
  parameter int ERR_LIMIT = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitIn,
  input  logic resyncIn,
  input  logic autoEn,
  input  logic nfasChkEn,
  input  logic mfRestart,
  input  logic mfReady,
  output logic [$clog2(TS_BITS)-1:0] bitCnt,
  output logic [$clog2(FRAME_TS)-1:0] tsCnt,
  output logic fasFrame,
  output logic frameStrobe,
  output logic losOut
);
  localparam int BIT_W = $clog2(TS_BITS);
  localparam int POS_W = $clog2(TS_BITS * FRAME_TS);
  localparam int ERR_W = $clog2(ERR_LIMIT + 1);

  ctlStrobe_t       strobe;
  dpFlags_t         flags;
  logic [POS_W-1:0] pos;
  syncState_t       stateQ;
  logic [ERR_W-1:0] fasErrCnt, nfasErrCnt;

  e1fa_datapath #(
    .TS_BITS(TS_BITS), .FRAME_TS(FRAME_TS), .FAS_WORD(FAS_WORD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .resyncIn(resyncIn),
    .strobe(strobe), .flags(flags), .pos(pos)
  );

  e1fa_control #(
    .ERR_LIMIT(ERR_LIMIT), .ERR_W(ERR_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .flags(flags), .autoEn(autoEn),
    .nfasChkEn(nfasChkEn), .mfRestart(mfRestart), .strobe(strobe),
    .stateQ(stateQ), .fasErrCnt(fasErrCnt), .nfasErrCnt(nfasErrCnt)
  );

  assign bitCnt      = pos[BIT_W-1:0];
  assign tsCnt       = pos[POS_W-1:BIT_W];
  assign frameStrobe = (pos == '0);
  assign fasFrame    = flags.fasPhase;
  assign losOut      = (stateQ != ST_SYNC) | ~mfReady;

endmodule

// File: rtl/e1fa_checker.sv
module e1fa_checker
  import e1fa_pkg::*;
#(
  parameter int TS_BITS  = 8,
  parameter int FRAME_TS = 32,
  parameter int ERR_W    = 2
) (
  input logic clk,
  input logic rstN,
  input logic resyncIn,
  input logic mfRestart,
  input logic mfReady,
  input logic losOut,
  input logic fasFrame,
  input logic frameStrobe,
  input logic [$clog2(TS_BITS)-1:0] bitCnt,
  input logic [$clog2(FRAME_TS)-1:0] tsCnt,
  input syncState_t stateQ,
  input logic [ERR_W-1:0] fasErrCnt,
  input logic [ERR_W-1:0] nfasErrCnt
);
  localparam logic [$clog2(TS_BITS)-1:0]  BIT_MAX = '1;
  localparam logic [$clog2(FRAME_TS)-1:0] TS_MAX  = '1;

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (!losOut && bitCnt == BIT_MAX && tsCnt == TS_MAX) |=> frameStrobe); // R2

  AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    (!losOut && bitCnt == BIT_MAX && tsCnt == TS_MAX) |=> (fasFrame != $past(fasFrame))); // R2

  AST_BIT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!losOut && bitCnt != BIT_MAX) |=> (bitCnt == $past(bitCnt) + 1'b1)); // R2

  AST_MANUAL_HUNT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resyncIn) |=> losOut); // R9

  AST_MF_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    mfRestart |=> losOut); // R10

  AST_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    !mfReady |-> losOut); // R11

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != ST_SYNC) |-> (fasErrCnt == '0 && nfasErrCnt == '0)); // R12

endmodule

bind e1_frame_sync e1fa_checker #(
  .TS_BITS(TS_BITS), .FRAME_TS(FRAME_TS), .ERR_W($clog2(ERR_LIMIT + 1))
) u_chk (
  .clk(clk), .rstN(rstN), .resyncIn(resyncIn), .mfRestart(mfRestart),
  .mfReady(mfReady), .losOut(losOut), .fasFrame(fasFrame),
  .frameStrobe(frameStrobe), .bitCnt(bitCnt), .tsCnt(tsCnt),
  .stateQ(stateQ), .fasErrCnt(fasErrCnt), .nfasErrCnt(nfasErrCnt)
);

// File: tb/e1_frame_sync_bench.sv
module e1_frame_sync_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, bitIn, resyncIn, autoEn, nfasChkEn, mfRestart, mfReady;
  logic [2:0] bitCnt;
  logic [4:0] tsCnt;
  logic fasFrame, frameStrobe, losOut;

  e1_frame_sync u_e1_frame_sync (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .resyncIn(resyncIn),
    .autoEn(autoEn), .nfasChkEn(nfasChkEn), .mfRestart(mfRestart),
    .mfReady(mfReady), .bitCnt(bitCnt), .tsCnt(tsCnt), .fasFrame(fasFrame),
    .frameStrobe(frameStrobe), .losOut(losOut)
  );

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;
  localparam int FAS = 27;  // 0011011

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- transmitter ----------------
  int txPos = 37, curPos = 0;
  bit txFas = 1, curFas = 0;
  bit corrupt = 0, nfasZero = 0, fakeArm = 0, lfsrMode = 0;
  int lfsr = 16'hACE1;

  always @(negedge clk) begin
    bit b;
    #1;
    b = lfsrMode ? lfsr[0] : 1'b1;
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h0000B400 : 0);
    if (txPos < 8) begin
      if (txFas) begin
        b = (txPos == 0) ? 1'b1 : 1'((FAS >> (7 - txPos)) & 1);
        if (corrupt && txPos == 7) b = ~b;
      end else begin
        b = (txPos == 1) ? !nfasZero : 1'b1;
      end
    end else if (fakeArm && txFas && txPos >= 40 && txPos < 48) begin
      b = (txPos == 40) ? 1'b1 : 1'((FAS >> (47 - txPos)) & 1);
    end
    bitIn = b;
    curPos = txPos;
    curFas = txFas;
    txPos++;
    if (txPos == 256) begin txPos = 0; txFas = !txFas; end
  end

  // ---------------- reference model ----------------
  int mState = 0, mPos = 0, mHist = 0, mFe = 0, mNe = 0;
  bit mFas = 0, mPrev = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mPos = 0; mFas = 0; mHist = 0; mFe = 0; mNe = 0; mPrev = 0;
    end else begin
      int w, ns;
      bit edgeSeen, hunt, realign, b2;
      w = ((mHist << 1) | bitIn) & 127;
      edgeSeen = resyncIn && !mPrev;
      mPrev = resyncIn;
      hunt = edgeSeen || mfRestart;
      realign = 0;
      ns = mState;
      if (mState == 3 && mPos == 7) begin
        if (mFas) begin
          mFe = (w == FAS) ? 0 : ((mFe < 3) ? mFe + 1 : 3);
          if (autoEn && w != FAS && mFe == 3) hunt = 1;
        end else begin
          b2 = 1'((w >> 6) & 1);
          mNe = b2 ? 0 : ((mNe < 3) ? mNe + 1 : 3);
          if (autoEn && nfasChkEn && !b2 && mNe == 3) hunt = 1;
        end
      end
      if (hunt) ns = 0;
      else if (mState == 0 && w == FAS) begin ns = 1; realign = 1; end
      else if (mState == 1 && mPos == 7) ns = ((w >> 6) & 1) ? 2 : 0;
      else if (mState == 2 && mPos == 7) ns = (w == FAS) ? 3 : 0;
      if (ns != 3) begin mFe = 0; mNe = 0; end
      mState = ns;
      mHist = w;
      if (realign) begin mPos = 8; mFas = 1; end
      else if (mPos == 255) begin mPos = 0; mFas = !mFas; end
      else mPos++;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      check(bitCnt == 3'(mPos % 8), "R2", "model bitCnt", bitCnt, mPos % 8);
      check(tsCnt == 5'(mPos / 8), "R2", "model tsCnt", tsCnt, mPos / 8);
      check(frameStrobe == (mPos == 0), "R2", "model frameStrobe", frameStrobe, mPos == 0);
      check(fasFrame == mFas, "R3", "model fasFrame", fasFrame, mFas);
      check(losOut == (mState != 3 || !mfReady), "R11", "model losOut", losOut,
            (mState != 3 || !mfReady));
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  task automatic tick();
    @(negedge clk); #2;
  endtask

  task automatic waitTx(input int p, input bit f);
    do tick(); while (!(txPos == p && txFas == f));
  endtask

  task automatic waitSync(input string req);
    for (int i = 0; i < 5000 && losOut; i++) tick();
    check(!losOut, req, "lock reached", losOut, 0);
  endtask

  task automatic checkAligned(input string req);
    check(bitCnt == 3'(curPos % 8), req, "bitCnt vs line", bitCnt, curPos % 8);
    check(tsCnt == 5'(curPos / 8), req, "tsCnt vs line", tsCnt, curPos / 8);
    check(fasFrame == curFas, req, "fasFrame vs line", fasFrame, curFas);
  endtask

  task automatic corruptFas(input int n);
    for (int k = 0; k < n; k++) begin
      waitTx(0, 1); corrupt = 1;
      waitTx(0, 0); corrupt = 0;
    end
  endtask

  task automatic zeroBit2(input int n);
    for (int k = 0; k < n; k++) begin
      waitTx(0, 0); nfasZero = 1;
      waitTx(0, 1); nfasZero = 0;
    end
  endtask

  initial begin
    rstN = 0; resyncIn = 0; autoEn = 1; nfasChkEn = 0; mfRestart = 0; mfReady = 1;
    repeat (3) tick();
    // R1 reset state
    check(losOut == 1, "R1", "losOut in reset", losOut, 1);
    check(bitCnt == 0 && tsCnt == 0, "R1", "position in reset", {tsCnt, bitCnt}, 0);
    check(frameStrobe == 1, "R1", "frameStrobe in reset", frameStrobe, 1);
    check(fasFrame == 0, "R1", "fasFrame in reset", fasFrame, 0);
    rstN = 1;

    // R3 R4 first lock
    waitSync("R4");
    checkAligned("R3");

    // R6: two errors tolerated, clean word clears the run, third in a row hunts
    corruptFas(2);
    check(!losOut, "R6", "two errored words", losOut, 0);
    waitTx(0, 1); waitTx(0, 0);
    corruptFas(2);
    check(!losOut, "R6", "run cleared by good word", losOut, 0);
    corruptFas(1);
    check(losOut, "R6", "third errored word", losOut, 1);
    waitSync("R6");

    // R8: auto resync disabled
    autoEn = 0;
    corruptFas(4);
    check(!losOut, "R8", "errors ignored without autoEn", losOut, 0);
    autoEn = 1;
    waitTx(0, 1); waitTx(0, 0);
    check(!losOut, "R8", "good word after re-enable", losOut, 0);

    // R7: bit-2 criterion
    zeroBit2(3);
    check(!losOut, "R7", "bit2 errors ignored when disabled", losOut, 0);
    nfasChkEn = 1;
    waitTx(0, 0); waitTx(0, 1);
    zeroBit2(2);
    check(!losOut, "R7", "two bit2 errors", losOut, 0);
    zeroBit2(1);
    check(losOut, "R7", "third bit2 error", losOut, 1);
    nfasChkEn = 0;
    waitSync("R7");

    // R12 + R9: errors before a manual hunt are forgotten
    corruptFas(2);
    resyncIn = 1;
    tick();
    check(losOut, "R9", "hunt after rising edge", losOut, 1);
    waitSync("R9");
    corruptFas(1);
    check(!losOut, "R12", "old errors not carried over", losOut, 0);
    resyncIn = 0;
    repeat (4) tick();
    check(!losOut, "R9", "falling edge has no effect", losOut, 0);

    // R11
    mfReady = 0; tick();
    check(losOut, "R11", "mfReady low forces loss", losOut, 1);
    mfReady = 1; tick();
    check(!losOut, "R11", "mfReady back high", losOut, 0);

    // R10
    mfRestart = 1; tick(); mfRestart = 0;
    check(losOut, "R10", "restart pulse", losOut, 1);
    waitSync("R10");

    // R4: bit 2 of the next frame must be 1
    waitTx(16, 0); resyncIn = 1;
    waitTx(0, 0); nfasZero = 1;
    waitTx(0, 1); nfasZero = 0;
    waitTx(0, 0); waitTx(128, 0);
    check(losOut, "R4", "candidate with bit2=0 rejected", losOut, 1);
    resyncIn = 0;
    waitSync("R4");
    checkAligned("R4");

    // R5: spurious word in payload
    waitTx(16, 1); fakeArm = 1; resyncIn = 1;
    waitTx(0, 0); fakeArm = 0;
    waitTx(0, 1); waitTx(0, 0);
    check(losOut, "R5", "spurious candidate not accepted", losOut, 1);
    resyncIn = 0;
    waitSync("R5");
    checkAligned("R5");

    // random payload, model comparison only
    lfsrMode = 1; resyncIn = 1;
    repeat (6000) tick();
    resyncIn = 0;
    repeat (10) tick();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule